// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned operands with no clock and no state: the product follows the operands through combinational logic alone. At the default width it takes two 4-bit values and returns their full 8-bit product, so no result bit is ever lost.

The datapath is a square grid built from one repeated cell. Each cell ANDs one bit of each operand to form a one-bit partial product. It then adds that bit, a sum bit from the row above and a carry from its right-hand neighbour, and gives out a sum bit and a carry bit. Carries travel along each row. Sum bits move one column down and to the right into the next row. Where a cell has no neighbour at the edge of the grid, the missing input is tied to constant zero, so no special edge cell is needed. Each row's lowest sum bit becomes one low product bit. The last row supplies the upper half of the product.

Top module: `mul_array4`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product `op_a * op_b` as a 2*W-bit value (8 bits at the default W of 4).
- R2: Bit 0 of `product` equals the AND of bit 0 of `op_a` and bit 0 of `op_b`.
- R3: When either operand is zero, `product` is all zeros, whatever the other operand is.
- R4: The largest operands, 15 times 15, give 225 (8'hE1), so the top product bit is kept.
- R5: Operands 4'b1010 and 4'b1100 give 8'b01111000 (10 times 12 gives 120).
- R6: Swapping the two operands leaves `product` unchanged.
- R7: The block has no clock or state. `product` reflects new operand values without any clock edge in between.
- R8: Every cell's two outputs, read as a 2-bit number {carry, sum}, equal the arithmetic sum of its AND bit, its sum input and its carry input. Each row's carry-out and sum bits, read together, equal the row's partial-product word plus its incoming sum word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned; bit i selects the partial product added in row i |
| product | output | 8 | Full unsigned product |

## Verification
The bench applies every one of the 256 operand pairs and compares each result with a behavioural multiply, so a cell wired to the wrong column or a dropped carry shows up as wrong product bits. Zero operands catch a constant edge tied to one instead of zero, because a nonzero product would then appear. The 15 times 15 case catches a lost final carry-out, which would clear bit 7. A swap test catches a design that treats the two operands unequally, for example by misplacing one side's bits in the rows. A mid-cycle operand change with no clock edge exposes any hidden register, which would leave the old product on the output.

// File: rtl/mul_array_pkg.sv
package mul_array_pkg;
    // Default operand width for the array
    localparam int unsigned OPERAND_W = 4;
    // Product width derived from the operand width
    localparam int unsigned PRODUCT_W = 2 * OPERAND_W;
endpackage

// File: rtl/mul_array_cell.sv
module mul_array_cell (
    input  logic x_bit,
    input  logic y_bit,
    input  logic sum_in,
    input  logic carry_in,
    output logic sum_out,
    output logic carry_out
);
    logic pp_bit;

    always_comb begin
        pp_bit    = x_bit & y_bit;
        sum_out   = pp_bit ^ sum_in ^ carry_in;
        carry_out = (pp_bit & sum_in) | (pp_bit & carry_in) | (sum_in & carry_in);
    end

    always_comb begin
        // R8
        cell_sum_chk: assert ({1'b0, carry_out} * 2'd2 + {1'b0, sum_out} ==
                              {1'b0, x_bit & y_bit} + {1'b0, sum_in} + {1'b0, carry_in})
            else $error("cell output does not match bit count");
    end
endmodule

// File: rtl/mul_array_row.sv
module mul_array_row #(
    parameter int unsigned W = mul_array_pkg::OPERAND_W
) (
    input  logic [W-1:0] mcand,
    input  logic         mplier_bit,
    input  logic [W-1:0] sum_word_in,
    input  logic         row_carry_in,
    output logic [W-1:0] sum_word_out,
    output logic         row_carry_out
);
    logic [W:0] ripple;

    assign ripple[0] = row_carry_in;

    for (genvar j = 0; j < W; j++) begin : g_cell
        mul_array_cell u_cell (
            .x_bit     (mcand[j]),
            .y_bit     (mplier_bit),
            .sum_in    (sum_word_in[j]),
            .carry_in  (ripple[j]),
            .sum_out   (sum_word_out[j]),
            .carry_out (ripple[j+1])
        );
    end

    assign row_carry_out = ripple[W];

    logic [W:0] row_expect;
    always_comb begin
        row_expect = {1'b0, mcand & {W{mplier_bit}}} + {1'b0, sum_word_in}
                   + (W+1)'(row_carry_in);
        // R8
        row_total_chk: assert ({row_carry_out, sum_word_out} == row_expect)
            else $error("row result does not match its inputs");
    end
endmodule

// File: rtl/mul_array4.sv
module mul_array4 #(
    parameter int unsigned W = mul_array_pkg::OPERAND_W
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0][W-1:0] row_sum;
    logic [W-1:0][W-1:0] row_sin;
    logic [W-1:0]        row_co;

    for (genvar i = 0; i < W; i++) begin : g_row
        if (i == 0) begin : g_first
            // top edge: no incoming sums
            assign row_sin[i] = '0;
        end else begin : g_next
            // sums shift one column right; previous carry-out enters the top column
            assign row_sin[i] = {row_co[i-1], row_sum[i-1][W-1:1]};
        end

        mul_array_row #(.W(W)) u_row (
            .mcand         (op_a),
            .mplier_bit    (op_b[i]),
            .sum_word_in   (row_sin[i]),
            .row_carry_in  (1'b0),
            .sum_word_out  (row_sum[i]),
            .row_carry_out (row_co[i])
        );

        assign product[i] = row_sum[i][0];
    end

    assign product[PW-1:W] = {row_co[W-1], row_sum[W-1][W-1:1]};

    always_comb begin
        // R1
        full_product_chk: assert (product == PW'(op_a) * PW'(op_b))
            else $error("product differs from operand product");
        // R2
        lsb_and_chk: assert (product[0] == (op_a[0] & op_b[0]))
            else $error("product lsb wrong");
        // R3
        zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("zero operand gave nonzero product");
    end
endmodule

// File: tb/mul_array4_tb.sv
`timescale 1ns/1ps
module mul_array4_tb;
    logic       clk = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [7:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] got_tab [256];

    always #2 clk = ~clk;

    mul_array4 u_dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d got=%0d expected=%0d", tag, op_a, op_b, got, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(posedge clk);
        #1;
        op_a = 4'(a);
        op_b = 4'(b);
        exp_q.push_back(8'(a * b));
        @(negedge clk);
        check("R1", product, exp_q.pop_front());
    endtask

    initial begin
        // reset state: both operands zero
        #1;
        check("R3", product, 8'd0);

        // exhaustive sweep against behavioural multiply
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(a, b);
                got_tab[a*16+b] = product;
                check("R2", {7'd0, product[0]}, {7'd0, 1'(a & b & 1)});
                if (a == 0 || b == 0) check("R3", product, 8'd0);
            end
        end

        // R6: swapped operands
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                check("R6", got_tab[b*16+a], got_tab[a*16+b]);
            end
        end

        // R4: maximum operands
        apply(15, 15);
        check("R4", product, 8'hE1);

        // R5: worked example
        apply(10, 12);
        check("R5", product, 8'b0111_1000);

        // R7: change mid-cycle, no clock edge in between
        @(posedge clk);
        #0.5;
        op_a = 4'd7; op_b = 4'd9;
        #0.5;
        check("R7", product, 8'd63);
        op_a = 4'd13; op_b = 4'd11;
        #0.5;
        check("R7", product, 8'd143);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule